// File: doc/BRIEF.md
# Two-Counter Event Monitor

This block counts hardware events for software profiling. A bank of event codes, each carrying a small group of sub-event lines, feeds two programmable 40-bit counters. Each counter has its own selector register. The selector picks one event code and masks its sub-event lines. It can also turn the per-cycle count into a threshold test, with an optional inversion and an optional rising-edge filter. A counter only runs when the global control register and its own selector both enable it.

When a counter wraps past 2^40 it sets a sticky overflow flag. Software clears that flag by writing a 1 to the matching bit of the acknowledge register. A level interrupt stays high while any flagged counter also has interrupt-on-overflow enabled. Software can preload a counter, for example to 2^40 minus a period, so that it overflows after a chosen number of events. A defined upper range of event codes is counted on counter 0 only.

All registers sit behind a simple port with an address, write data, a write strobe and combinational read data. A write takes effect at the clock edge where the strobe is high. Event inputs are sampled at each rising edge, and a counter's new value is visible right after that edge.

Top module: `evmon_unit`

## Requirements
- R1: After reset every register reads 0 and `irq` is low.
- R2: A counter advances at a clock edge only when both enable bits are set: its global bit in the control register (address 0, bit 0 for counter 0, bit 1 for counter 1) and the local enable at bit 22 of its selector.
- R3: With threshold field 0 (selector bits 31:24), a counter adds the number of set bits in (sub-event lines of the selected code AND unit mask) each cycle. The code is in selector bits 7:0 and the unit mask in bits 15:8. Code 0 is a valid event, lines of unselected codes have no effect, and a zero unit mask gives no counts.
- R4: With a nonzero threshold, a counter adds 1 in each cycle where the masked count is at least the threshold. When the invert bit (selector bit 23) is set, it adds 1 when the masked count is below the threshold instead.
- R5: With a nonzero threshold and the edge bit (selector bit 18) set, a counter adds 1 only in cycles where the threshold condition is true and was false in the previous cycle. The previous condition is tracked every cycle, from 0 at reset.
- R6: A counter wraps modulo 2^40. A wrap sets the sticky status flag of that counter, read at address 1 at bit position equal to the counter index.
- R7: Writing the acknowledge register (address 2, which reads as 0) with a 1 in bit i clears status flag i. A 0 in bit i leaves flag i unchanged.
- R8: `irq` is high exactly when some counter has its status flag set and its interrupt bit (selector bit 20) set.
- R9: Counters are at addresses 5 and 6 and read back the 40 bits written. A counter write in the same cycle as an increment wins over the increment.
- R10: Event codes 0xC3 through 0xFF give no increments on counter 1 but count normally on counter 0. Code 0xC2 counts on counter 1.
- R11: Selectors at addresses 3 and 4 read back all 32 bits as written. The control register reads back its 2 enable bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 40 | Write data |
| reg_we | input | 1 | Write strobe |
| reg_rdata | output | 40 | Read data for reg_addr, combinational |
| evt_sub | input | 2048 | Sub-event lines, 8 per code; code c uses bits 8c+7..8c |
| irq | output | 1 | Level overflow interrupt |

## Verification
The assertions assume a sub-event group never contributes more than its 8 lines in a cycle. From that they bound the count a counter can hold just after a wrap. They also assume register writes only touch the addresses listed in the requirements. The stimulus changes event lines and register controls only between rising edges. It keeps counting windows short, and it frames each window with writes to the global control register, so every edge that counts is known in advance. Preloads near 2^40 produce the wraps quickly.

// File: rtl/evmon_pkg.sv
package evmon_pkg;
    localparam int CNT_W   = 40;
    localparam int DATA_W  = CNT_W;
    localparam int SEL_W   = 32;
    localparam int ADDR_W  = 3;
    localparam int NUM_CTR = 2;

    // selector field positions
    localparam int F_CODE_LO  = 0;
    localparam int F_MASK_LO  = 8;
    localparam int F_EDGE     = 18;
    localparam int F_INTR     = 20;
    localparam int F_EN       = 22;
    localparam int F_INV      = 23;
    localparam int F_THR_LO   = 24;

    localparam logic [ADDR_W-1:0] A_GCTRL = 3'd0;
    localparam logic [ADDR_W-1:0] A_GSTAT = 3'd1;
    localparam logic [ADDR_W-1:0] A_ACK   = 3'd2;
    localparam logic [ADDR_W-1:0] A_SEL0  = 3'd3;
    localparam logic [ADDR_W-1:0] A_SEL1  = 3'd4;
    localparam logic [ADDR_W-1:0] A_CNT0  = 3'd5;
    localparam logic [ADDR_W-1:0] A_CNT1  = 3'd6;
endpackage

// File: rtl/evmon_filter.sv
module evmon_filter #(
    parameter int NUM_CODES = 256,
    parameter int SUB_W     = 8,
    parameter int IDX       = 0,
    parameter int ONLY0_LO  = 8'hC3,
    localparam int INC_W    = $clog2(SUB_W + 1)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_CODES*SUB_W-1:0] evt_sub,
    input  logic [7:0]                 code,
    input  logic [7:0]                 umask,
    input  logic [7:0]                 thr,
    input  logic                       edge_mode,
    input  logic                       invert,
    output logic [INC_W-1:0]           inc
);
    typedef struct packed {
        logic cond;
    } fstate_t;

    fstate_t st_d, st_q;
    logic [SUB_W-1:0] lines;
    logic [INC_W-1:0] raw;
    logic             cond;
    logic             blocked;

    always_comb begin
        lines = '0;
        if (32'(code) < NUM_CODES)
            lines = evt_sub[32'(code)*SUB_W +: SUB_W];
        raw = '0;
        for (int k = 0; k < SUB_W; k++) begin
            if (k < 8) raw = raw + INC_W'(lines[k] & umask[k % 8]);
            else       raw = raw + INC_W'(lines[k]);
        end
        cond    = invert ? (32'(raw) < 32'(thr)) : (32'(raw) >= 32'(thr));
        blocked = (IDX != 0) && (32'(code) >= ONLY0_LO);
        st_d.cond = cond;
        if (blocked)
            inc = '0;
        else if (thr == 8'd0)
            inc = raw;
        else if (edge_mode)
            inc = INC_W'(cond & ~st_q.cond);
        else
            inc = INC_W'(cond);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R3: a group can never add more than its own line count
    p_inc_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        inc <= INC_W'(SUB_W));

    // R5: in edge mode a count implies the condition was low last cycle
    p_edge_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_mode && thr != 8'd0 && inc != '0) |-> !st_q.cond);
endmodule

// File: rtl/evmon_counter.sv
module evmon_counter
    import evmon_pkg::*;
#(
    parameter int NUM_CODES = 256,
    parameter int SUB_W     = 8,
    parameter int IDX       = 0,
    parameter int ONLY0_LO  = 8'hC3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       g_en,
    input  logic                       sel_we,
    input  logic                       cnt_we,
    input  logic [DATA_W-1:0]          wdata,
    input  logic [NUM_CODES*SUB_W-1:0] evt_sub,
    output logic [SEL_W-1:0]           sel_o,
    output logic [CNT_W-1:0]           cnt_o,
    output logic                       ovf_o
);
    localparam int INC_W = $clog2(SUB_W + 1);
    localparam int SUM_W = CNT_W + 1;

    typedef struct packed {
        logic [SEL_W-1:0] sel;
        logic [CNT_W-1:0] cnt;
    } cstate_t;

    cstate_t st_d, st_q;
    logic [INC_W-1:0] inc;
    logic [SUM_W-1:0] sum;
    logic             active;

    evmon_filter #(
        .NUM_CODES(NUM_CODES), .SUB_W(SUB_W), .IDX(IDX), .ONLY0_LO(ONLY0_LO)
    ) u_filt (
        .clk       (clk),
        .rst_n     (rst_n),
        .evt_sub   (evt_sub),
        .code      (st_q.sel[F_CODE_LO +: 8]),
        .umask     (st_q.sel[F_MASK_LO +: 8]),
        .thr       (st_q.sel[F_THR_LO +: 8]),
        .edge_mode (st_q.sel[F_EDGE]),
        .invert    (st_q.sel[F_INV]),
        .inc       (inc)
    );

    always_comb begin
        st_d   = st_q;
        active = g_en & st_q.sel[F_EN];
        sum    = {1'b0, st_q.cnt} + SUM_W'(inc);
        ovf_o  = 1'b0;
        if (sel_we)
            st_d.sel = wdata[SEL_W-1:0];
        if (cnt_we) begin
            st_d.cnt = wdata[CNT_W-1:0];
        end else if (active) begin
            st_d.cnt = sum[CNT_W-1:0];
            ovf_o    = sum[CNT_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sel_o = st_q.sel;
    assign cnt_o = st_q.cnt;

    // R2: without a write and without both enables the count holds
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_we && !(g_en && st_q.sel[F_EN])) |=> $stable(st_q.cnt));

    // R6: right after a wrap the count is below one cycle's maximum
    p_wrap_small_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |=> (st_q.cnt < CNT_W'(SUB_W)));

    // R9: a counter write lands regardless of counting
    p_write_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_we |=> (st_q.cnt == $past(wdata[CNT_W-1:0])));
endmodule

// File: rtl/evmon_unit.sv
module evmon_unit
    import evmon_pkg::*;
#(
    parameter int NUM_CODES = 256,
    parameter int SUB_W     = 8,
    parameter int ONLY0_LO  = 8'hC3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [ADDR_W-1:0]          reg_addr,
    input  logic [DATA_W-1:0]          reg_wdata,
    input  logic                       reg_we,
    output logic [DATA_W-1:0]          reg_rdata,
    input  logic [NUM_CODES*SUB_W-1:0] evt_sub,
    output logic                       irq
);
    typedef struct packed {
        logic [NUM_CTR-1:0] gctrl;
        logic [NUM_CTR-1:0] stat;
    } ustate_t;

    ustate_t st_d, st_q;
    logic [NUM_CTR-1:0] ovf;
    logic [NUM_CTR-1:0] intr_en;
    logic [NUM_CTR-1:0] ack;
    logic [SEL_W-1:0]   sel_r [NUM_CTR];
    logic [CNT_W-1:0]   cnt_r [NUM_CTR];

    for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
        evmon_counter #(
            .NUM_CODES(NUM_CODES), .SUB_W(SUB_W), .IDX(i), .ONLY0_LO(ONLY0_LO)
        ) u_ctr (
            .clk     (clk),
            .rst_n   (rst_n),
            .g_en    (st_q.gctrl[i]),
            .sel_we  (reg_we && reg_addr == A_SEL0 + ADDR_W'(i)),
            .cnt_we  (reg_we && reg_addr == A_CNT0 + ADDR_W'(i)),
            .wdata   (reg_wdata),
            .evt_sub (evt_sub),
            .sel_o   (sel_r[i]),
            .cnt_o   (cnt_r[i]),
            .ovf_o   (ovf[i])
        );
        assign intr_en[i] = sel_r[i][F_INTR];
    end

    always_comb begin
        st_d = st_q;
        ack  = (reg_we && reg_addr == A_ACK) ? reg_wdata[NUM_CTR-1:0] : '0;
        if (reg_we && reg_addr == A_GCTRL)
            st_d.gctrl = reg_wdata[NUM_CTR-1:0];
        // a wrap in the same cycle as its acknowledge keeps the flag
        st_d.stat = (st_q.stat & ~ack) | ovf;

        case (reg_addr)
            A_GCTRL: reg_rdata = DATA_W'(st_q.gctrl);
            A_GSTAT: reg_rdata = DATA_W'(st_q.stat);
            A_SEL0:  reg_rdata = DATA_W'(sel_r[0]);
            A_SEL1:  reg_rdata = DATA_W'(sel_r[1]);
            A_CNT0:  reg_rdata = cnt_r[0];
            A_CNT1:  reg_rdata = cnt_r[1];
            default: reg_rdata = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq = |(st_q.stat & intr_en);

    // R7: a flag stays set until its acknowledge bit is written
    p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.stat[0] && !ack[0]) |=> st_q.stat[0]);
    p_sticky1_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.stat[1] && !ack[1]) |=> st_q.stat[1]);

    // R6: a wrap always leaves its flag set
    p_wrap_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ovf[0] |=> st_q.stat[0]);

    // R8: interrupt never without a flag
    p_irq_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (st_q.stat != '0));
endmodule

// File: tb/evmon_unit_test.sv
`timescale 1ns/1ps
module evmon_unit_test;
    localparam int NC = 256;
    localparam int SW = 8;
    localparam logic [2:0] GCTRL = 3'd0, GSTAT = 3'd1, ACK = 3'd2;
    localparam logic [2:0] SEL0 = 3'd3, CNT0 = 3'd5;
    localparam logic [39:0] EN_BIT = 40'h40_0000;
    localparam logic [39:0] INTR_BIT = 40'h10_0000;
    localparam logic [39:0] EDGE_BIT = 40'h4_0000;

    // {ctr, code, umask, thr, inv, pattern, cycles, expected}
    localparam logic [63:0] VEC [10] = '{
        64'h0_00_FF_00_0_0F_03_000C,
        64'h0_2A_0F_00_0_FF_05_0014,
        64'h0_16_FF_03_0_07_04_0004,
        64'h0_16_FF_04_0_07_04_0000,
        64'h0_16_FF_04_1_07_04_0004,
        64'h1_12_FF_00_0_03_06_000C,
        64'h1_C3_FF_00_0_FF_03_0000,
        64'h0_FF_FF_00_0_01_03_0003,
        64'h1_C2_FF_00_0_01_02_0002,
        64'h0_40_00_00_0_FF_03_0000
    };
    localparam string VTAG [10] = '{"R3","R3","R4","R4","R4","R2","R10","R10","R10","R3"};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [2:0] reg_addr = '0;
    logic [39:0] reg_wdata = '0;
    logic reg_we = 1'b0;
    logic [39:0] reg_rdata;
    logic [NC*SW-1:0] evt_sub = '0;
    logic irq;
    int checks = 0;
    int errors = 0;
    logic [39:0] got;

    always #2.5 clk = ~clk;

    evmon_unit uut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_we(reg_we), .reg_rdata(reg_rdata), .evt_sub(evt_sub), .irq(irq)
    );

    task automatic check(input string tag, input logic [39:0] act, input logic [39:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [39:0] d);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [39:0] d);
        reg_addr = a;
        #0.5;
        d = reg_rdata;
    endtask

    task automatic set_sub(input int code, input logic [7:0] pat);
        evt_sub = '1;
        evt_sub[code*SW +: SW] = pat;
    endtask

    // exactly n edges with the global enable bits gv
    task automatic run(input int n, input logic [39:0] gv);
        wr(GCTRL, gv);
        repeat (n - 1) @(negedge clk);
        wr(GCTRL, 40'd0);
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(GCTRL, got); check("R1 gctrl", got, 40'd0);
        rd(GSTAT, got); check("R1 status", got, 40'd0);
        rd(SEL0, got);  check("R1 sel0", got, 40'd0);
        rd(CNT0 + 3'd1, got); check("R1 cnt1", got, 40'd0);
        check("R1 irq", {39'd0, irq}, 40'd0);

        // R11 readback
        wr(SEL0, 40'hFF_FFFF_FFFF);
        rd(SEL0, got); check("R11 sel0 readback", got, 40'hFFFF_FFFF);
        wr(GCTRL, 40'h3);
        rd(GCTRL, got); check("R11 gctrl readback", got, 40'h3);
        wr(GCTRL, 40'h0);
        wr(SEL0, 40'd0);
        rd(ACK, got); check("R7 ack reads zero", got, 40'd0);

        // table of counting patterns
        for (int v = 0; v < 10; v++) begin
            logic [63:0] e;
            int c;
            logic [39:0] sv;
            e = VEC[v];
            c = int'(e[63:60]);
            sv = EN_BIT | 40'(e[59:52]) | (40'(e[51:44]) << 8)
                 | (40'(e[43:36]) << 24) | (40'(e[32]) << 23);
            wr(SEL0 + 3'(1 - c), 40'd0);
            wr(SEL0 + 3'(c), sv);
            wr(CNT0 + 3'(c), 40'd0);
            set_sub(int'(e[59:52]), e[31:24]);
            run(int'(e[23:16]), 40'd1 << c);
            evt_sub = '0;
            rd(CNT0 + 3'(c), got);
            check(VTAG[v], got, 40'(e[15:0]));
        end
        wr(SEL0 + 3'd1, 40'd0);

        // R2 local enable off, global on
        wr(SEL0, 40'h0000_FF05);
        wr(CNT0, 40'd0);
        set_sub(5, 8'hFF);
        run(4, 40'h1);
        rd(CNT0, got); check("R2 local enable off", got, 40'd0);
        // R2 local on, global only for other counter
        wr(SEL0, EN_BIT | 40'h0000_FF05);
        run(4, 40'h2);
        rd(CNT0, got); check("R2 global bit off", got, 40'd0);

        // R9 preload and masking
        wr(CNT0 + 3'd1, 40'h7F_FFFF_FFFF);
        rd(CNT0 + 3'd1, got); check("R9 preload readback", got, 40'h7F_FFFF_FFFF);
        wr(CNT0 + 3'd1, 40'd0);

        // R6 wrap with interrupt, R8
        wr(SEL0, EN_BIT | INTR_BIT | 40'h0000_0105);
        wr(CNT0, 40'hFF_FFFF_FFFE);
        set_sub(5, 8'h01);
        run(3, 40'h1);
        rd(CNT0, got); check("R6 wrapped count", got, 40'd1);
        rd(GSTAT, got); check("R6 status flag", got, 40'h1);
        check("R8 irq raised", {39'd0, irq}, 40'd1);

        // R7 acknowledge
        wr(ACK, 40'h0);
        rd(GSTAT, got); check("R7 zero ack keeps flag", got, 40'h1);
        wr(ACK, 40'h2);
        rd(GSTAT, got); check("R7 other bit keeps flag", got, 40'h1);
        check("R8 irq still high", {39'd0, irq}, 40'd1);
        wr(ACK, 40'h1);
        rd(GSTAT, got); check("R7 ack clears flag", got, 40'h0);
        check("R8 irq dropped", {39'd0, irq}, 40'd0);

        // R8 wrap without interrupt bit
        wr(SEL0, EN_BIT | 40'h0000_0105);
        wr(CNT0, 40'hFF_FFFF_FFFF);
        run(1, 40'h1);
        rd(GSTAT, got); check("R6 flag without intr", got, 40'h1);
        check("R8 irq masked", {39'd0, irq}, 40'd0);
        wr(ACK, 40'h1);

        // R9 write wins over increment
        wr(CNT0, 40'd0);
        wr(GCTRL, 40'h1);
        wr(CNT0, 40'd100);
        rd(CNT0, got); check("R9 write priority", got, 40'd100);
        @(negedge clk);
        rd(CNT0, got); check("R9 counts after write", got, 40'd101);
        wr(GCTRL, 40'h0);

        // R5 edge mode: pattern 1,1,0,1,0,0,1,1,1,0 has 3 rises
        evt_sub = '0;
        wr(SEL0, EN_BIT | EDGE_BIT | 40'h0100_FF07);
        wr(CNT0, 40'd0);
        wr(GCTRL, 40'h1);
        for (int k = 0; k < 10; k++) begin
            logic [9:0] pat;
            pat = 10'b01_1100_1011;
            evt_sub[7*SW +: SW] = pat[k] ? 8'h01 : 8'h00;
            @(negedge clk);
        end
        evt_sub = '0;
        wr(GCTRL, 40'h0);
        rd(CNT0, got); check("R5 rising edges", got, 40'd3);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule